// File: doc/BRIEF.md
# Double-Buffered DMA Channel Controller

A single-channel DMA engine that software steers through three 32-bit registers: a control/status word, a transfer address and a byte count. The channel holds an active address/count pair and one queued pair behind it. While the active transfer runs, software can park the following transfer in the queue. When the active count runs out, the queued pair takes over at once, so chained transfers run without software turnaround between them.

Each byte moves as one beat on a memory request port. That port is a valid/ready stream. Once the controller raises `mem_req_valid`, it keeps it high, and keeps `mem_req_addr` and `mem_req_last` unchanged, until a cycle in which `mem_req_ready` is high. The beat is accepted in that cycle. The memory side may hold `mem_req_ready` low for any number of cycles, and no beat is lost or repeated. `mem_err` is sampled only in a cycle that accepts a beat. Beats are grouped into bursts of a programmable length, with one idle cycle after each burst. A one-cycle device strobe marks every good beat.

Completion, errors and device requests raise status flags and an interrupt line. Software acknowledges the flags by writing back the status word it read. A self-clearing soft reset returns the channel to idle. If a beat is stalled when the reset is written, the reset first lets that beat finish (the drain phase).

Top module: `dbd_dma_chan`

## Requirements
- R1: After reset the control/status word reads as the device ID alone in bits 31:28 (parameter, default 5) with all other bits 0; `irq` and `mem_req_valid` are low.
- R2: An address write (offset 0x4) commits the staged count (offset 0x8, low 24 bits kept, upper bits dropped) and the address as the active pair, setting bit 26. It is ignored while DMA enable (bit 9) is clear. Offsets 0x4 and 0x8 read back the active address and count.
- R3: With bit 26 set, an address write goes to the queued pair and sets bit 27, but only when queue enable (bit 24) is set and bit 27 is clear; otherwise the write is dropped.
- R4: Each accepted beat uses the active address, then advances the address by 1 and lowers the count by 1. A stalled request keeps valid and address unchanged. `mem_req_write` follows bit 8.
- R5: Bits 19:18 choose the burst length (00=4, 01=8, 10=1, 11=16). `mem_req_last` marks the final beat of each burst and the final beat of the transfer, and one idle cycle follows every such beat.
- R6: On the final beat, terminal count (bit 14) is set, and interrupt pending (bit 0) is also set unless bit 23 is set. Bit 26 clears when no queued pair takes over.
- R7: When the transfer completes with bit 27 and bit 24 set, the queued pair becomes active at the same edge, bit 27 clears, and beats continue from the queued address.
- R8: Bits 0, 1 and 14 are write-1-to-clear, so writing back the value just read acknowledges them. Bits 4, 8, 9, 13, 18, 19, 23 and 24 take the written value.
- R9: `irq` is high exactly when bit 4 is set and bit 0 or bit 1 is set.
- R10: `mem_err` on an accepted beat sets error pending (bit 1). That beat leaves address and count unchanged, and no further beat is requested while bit 1 is set.
- R11: A high `dev_irq` sets bit 0 without setting bit 14.
- R12: Writing 1 to bit 7 clears all control bits, flags and loaded bits, and bit 7 reads 0. If a request is stalled at that moment, bits 2 and 10 read 1 and the request is held until accepted, and then both clear.
- R13: With the byte counter disabled (bit 13 = 0), the count is not decremented and terminal count never sets; beats continue until DMA enable is cleared.
- R14: `dev_strobe` is high for one cycle, one cycle after each accepted beat that had no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0, 0x4, 0x8) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req_valid | output | 1 | Beat request valid |
| mem_req_ready | input | 1 | Beat accepted by memory |
| mem_req_addr | output | 32 | Beat byte address |
| mem_req_write | output | 1 | Beat direction, 1 = write to memory |
| mem_req_last | output | 1 | Final beat of a burst or transfer |
| mem_err | input | 1 | Error response for the accepted beat |
| dev_irq | input | 1 | Device interrupt request |
| dev_strobe | output | 1 | One-cycle pulse per good beat |
| irq | output | 1 | Interrupt output |

## Verification
The embedded assertions check on every cycle the stream rules: a stalled request keeps its valid and address, and every last beat is followed by an idle cycle. They also check that the count steps down by one per good beat, that a queued pair leaves the queue only by becoming active, that error pending rises only after an errored beat, that terminal count brings interrupt pending unless suppressed, and that draining implies a pending cycle. Only the bench scenarios can show the end-to-end results: the full address sequence of a chained transfer, which writes get dropped, the write-back acknowledge, the drain sequence after a soft reset, and free-running mode with the counter off.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int REG_W = 32;

  // control/status bit positions (decoded by software)
  localparam int B_INT_PEND = 0;
  localparam int B_ERR_PEND = 1;
  localparam int B_DRAIN    = 2;
  localparam int B_INT_EN   = 4;
  localparam int B_SOFT_RST = 7;
  localparam int B_WR_DIR   = 8;
  localparam int B_EN_DMA   = 9;
  localparam int B_CYC_PEND = 10;
  localparam int B_EN_CNT   = 13;
  localparam int B_TC       = 14;
  localparam int B_BURST_LO = 18;
  localparam int B_TCI_DIS  = 23;
  localparam int B_EN_NEXT  = 24;
  localparam int B_ACTIVE   = 25;
  localparam int B_A_LOAD   = 26;
  localparam int B_N_LOAD   = 27;

  typedef struct packed {
    logic       en_next;
    logic       tci_dis;
    logic [1:0] burst;
    logic       en_cnt;
    logic       en_dma;
    logic       write_dir;
    logic       int_en;
  } ctrl_t;

  function automatic int burst_len(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 1;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/dbd_pair_queue.sv
module dbd_pair_queue #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          drain,
  input  logic          en_dma,
  input  logic          en_next,
  input  logic          en_cnt,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic [31:0]   wdata,
  input  logic          beat_good,
  output logic [AW-1:0] act_addr,
  output logic [CW-1:0] act_cnt,
  output logic          a_loaded,
  output logic          na_loaded,
  output logic          finish
);
  logic [CW-1:0] stg_cnt, nxt_cnt;
  logic [AW-1:0] nxt_addr;
  logic promote, take, to_act, to_nxt;

  assign finish  = a_loaded && en_cnt &&
                   ((beat_good && act_cnt == CW'(1)) ||
                    (en_dma && !beat_good && act_cnt == '0));
  assign promote = finish && na_loaded && en_next;
  assign take    = wr_addr && en_dma && !soft_rst && !drain;
  assign to_act  = take && (!a_loaded || (finish && !promote));
  assign to_nxt  = take && !to_act && en_next && (!na_loaded || promote);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_cnt   <= '0;
      nxt_cnt   <= '0;
      nxt_addr  <= '0;
      act_cnt   <= '0;
      act_addr  <= '0;
      a_loaded  <= 1'b0;
      na_loaded <= 1'b0;
    end else begin
      if (wr_cnt) stg_cnt <= wdata[CW-1:0];
      if (soft_rst) begin
        a_loaded  <= 1'b0;
        na_loaded <= 1'b0;
      end else begin
        if (beat_good) begin
          act_addr <= act_addr + AW'(1);
          if (en_cnt) act_cnt <= act_cnt - CW'(1);
        end
        if (promote) begin
          act_addr <= nxt_addr;
          act_cnt  <= nxt_cnt;
          a_loaded <= 1'b1;
        end else if (to_act) begin
          act_addr <= wdata[AW-1:0];
          act_cnt  <= stg_cnt;
          a_loaded <= 1'b1;
        end else if (finish) begin
          a_loaded <= 1'b0;
        end
        if (to_nxt) begin
          nxt_addr  <= wdata[AW-1:0];
          nxt_cnt   <= stg_cnt;
          na_loaded <= 1'b1;
        end else if (promote) begin
          na_loaded <= 1'b0;
        end
      end
    end
  end

  // R7: a queued pair only leaves the queue by becoming active (or by soft reset)
  p_promote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(na_loaded) && $past(rst_n) && !$past(soft_rst)) |-> a_loaded)
    else $error("queued pair dropped without promotion");

  // R4: a good counted beat that does not finish lowers the count by one
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(beat_good && en_cnt && !finish && !soft_rst))
      |-> act_cnt == $past(act_cnt) - CW'(1))
    else $error("count did not step");
endmodule

// File: rtl/dbd_burst_seq.sv
module dbd_burst_seq #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          issue_ok,
  input  logic [1:0]    burst_code,
  input  logic          en_cnt,
  input  logic [CW-1:0] act_cnt,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          valid,
  output logic          last,
  output logic          hs,
  output logic          hold
);
  import dbd_pkg::*;
  localparam int IW = 4;

  logic [IW-1:0] idx;
  logic gap;

  assign last  = (int'(idx) >= burst_len(burst_code) - 1) ||
                 (en_cnt && act_cnt == CW'(1));
  assign valid = hold || (issue_ok && !gap);
  assign hs    = valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
      gap  <= 1'b0;
      idx  <= '0;
    end else begin
      hold <= valid && !mem_ready;
      gap  <= hs && last;
      if (soft_rst || (hs && (last || mem_err))) idx <= '0;
      else if (hs) idx <= idx + IW'(1);
    end
  end

  // R4: a stalled request stays valid
  p_hold_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !mem_ready) |=> valid)
    else $error("request withdrawn while stalled");

  // R5: an idle cycle follows every last beat
  p_gap_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && last) |=> !valid)
    else $error("no idle cycle after last beat");
endmodule

// File: rtl/dbd_csr_status.sv
module dbd_csr_status #(
  parameter logic [3:0] DEV_ID = 4'h5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_csr,
  input  logic [31:0]  wdata,
  input  logic         finish,
  input  logic         beat_err,
  input  logic         dev_irq,
  input  logic         mem_valid,
  input  logic         mem_ready,
  input  logic         cyc_pend,
  input  logic         a_loaded,
  input  logic         na_loaded,
  output dbd_pkg::ctrl_t ctrl,
  output logic         err_pend,
  output logic         drain,
  output logic         soft_rst,
  output logic [31:0]  csr_rd,
  output logic         irq
);
  import dbd_pkg::*;

  logic int_pend, tc, ack_int, ack_err, ack_tc;
  logic unused_wbits;

  assign unused_wbits = ^wdata;
  assign soft_rst = wr_csr && wdata[B_SOFT_RST];
  assign ack_int  = wr_csr && wdata[B_INT_PEND];
  assign ack_err  = wr_csr && wdata[B_ERR_PEND];
  assign ack_tc   = wr_csr && wdata[B_TC];
  assign irq      = ctrl.int_en && (int_pend || err_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      int_pend <= 1'b0;
      err_pend <= 1'b0;
      tc       <= 1'b0;
      drain    <= 1'b0;
    end else if (soft_rst) begin
      ctrl     <= '0;
      int_pend <= 1'b0;
      err_pend <= 1'b0;
      tc       <= 1'b0;
      drain    <= mem_valid && !mem_ready;
    end else begin
      if (wr_csr) begin
        ctrl.int_en    <= wdata[B_INT_EN];
        ctrl.write_dir <= wdata[B_WR_DIR];
        ctrl.en_dma    <= wdata[B_EN_DMA];
        ctrl.en_cnt    <= wdata[B_EN_CNT];
        ctrl.burst     <= wdata[B_BURST_LO+1:B_BURST_LO];
        ctrl.tci_dis   <= wdata[B_TCI_DIS];
        ctrl.en_next   <= wdata[B_EN_NEXT];
      end
      int_pend <= (int_pend && !ack_int) || (finish && !ctrl.tci_dis) || dev_irq;
      err_pend <= (err_pend && !ack_err) || beat_err;
      tc       <= (tc && !ack_tc) || finish;
      drain    <= drain && !(mem_valid && mem_ready);
    end
  end

  always_comb begin
    csr_rd                            = '0;
    csr_rd[B_INT_PEND]                = int_pend;
    csr_rd[B_ERR_PEND]                = err_pend;
    csr_rd[B_DRAIN]                   = drain;
    csr_rd[B_INT_EN]                  = ctrl.int_en;
    csr_rd[B_WR_DIR]                  = ctrl.write_dir;
    csr_rd[B_EN_DMA]                  = ctrl.en_dma;
    csr_rd[B_CYC_PEND]                = cyc_pend;
    csr_rd[B_EN_CNT]                  = ctrl.en_cnt;
    csr_rd[B_TC]                      = tc;
    csr_rd[B_BURST_LO+1:B_BURST_LO]   = ctrl.burst;
    csr_rd[B_TCI_DIS]                 = ctrl.tci_dis;
    csr_rd[B_EN_NEXT]                 = ctrl.en_next;
    csr_rd[B_ACTIVE]                  = a_loaded && ctrl.en_dma && !err_pend;
    csr_rd[B_A_LOAD]                  = a_loaded;
    csr_rd[B_N_LOAD]                  = na_loaded;
    csr_rd[31:28]                     = DEV_ID;
  end

  // R10: error pending only rises after an errored beat
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_pend) && $past(rst_n)) |-> $past(beat_err))
    else $error("error pending without errored beat");

  // R6: terminal count brings interrupt pending unless suppressed
  p_tc_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tc) && $past(rst_n) && !$past(ctrl.tci_dis)) |-> int_pend)
    else $error("terminal count without interrupt pending");
endmodule

// File: rtl/dbd_dma_chan.sv
module dbd_dma_chan #(
  parameter int         CNT_W  = 24,
  parameter logic [3:0] DEV_ID = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  output logic        mem_req_write,
  output logic        mem_req_last,
  input  logic        mem_err,
  input  logic        dev_irq,
  output logic        dev_strobe,
  output logic        irq
);
  import dbd_pkg::*;
  localparam int AW = REG_W;

  ctrl_t ctrl;
  logic wr_csr, wr_addr, wr_cnt;
  logic soft_rst, drain, err_pend, hold, hs;
  logic a_loaded, na_loaded, finish, issue_ok, beat_good, beat_err;
  logic [AW-1:0]    act_addr;
  logic [CNT_W-1:0] act_cnt;
  logic [31:0]      csr_rd;

  assign wr_csr  = reg_wen && reg_addr == 4'h0;
  assign wr_addr = reg_wen && reg_addr == 4'h4;
  assign wr_cnt  = reg_wen && reg_addr == 4'h8;

  assign beat_good = hs && !drain && !soft_rst && !mem_err;
  assign beat_err  = hs && !drain && !soft_rst && mem_err;
  assign issue_ok  = a_loaded && ctrl.en_dma && !err_pend && !drain &&
                     (!ctrl.en_cnt || act_cnt != '0);

  assign mem_req_addr  = act_addr;
  assign mem_req_write = ctrl.write_dir;

  dbd_csr_status #(.DEV_ID(DEV_ID)) u_status (
    .clk(clk), .rst_n(rst_n), .wr_csr(wr_csr), .wdata(reg_wdata),
    .finish(finish), .beat_err(beat_err), .dev_irq(dev_irq),
    .mem_valid(mem_req_valid), .mem_ready(mem_req_ready), .cyc_pend(hold),
    .a_loaded(a_loaded), .na_loaded(na_loaded), .ctrl(ctrl),
    .err_pend(err_pend), .drain(drain), .soft_rst(soft_rst),
    .csr_rd(csr_rd), .irq(irq)
  );

  dbd_pair_queue #(.AW(AW), .CW(CNT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .drain(drain),
    .en_dma(ctrl.en_dma), .en_next(ctrl.en_next), .en_cnt(ctrl.en_cnt),
    .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wdata(reg_wdata),
    .beat_good(beat_good), .act_addr(act_addr), .act_cnt(act_cnt),
    .a_loaded(a_loaded), .na_loaded(na_loaded), .finish(finish)
  );

  dbd_burst_seq #(.CW(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .issue_ok(issue_ok),
    .burst_code(ctrl.burst), .en_cnt(ctrl.en_cnt), .act_cnt(act_cnt),
    .mem_ready(mem_req_ready), .mem_err(mem_err), .valid(mem_req_valid),
    .last(mem_req_last), .hs(hs), .hold(hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_strobe <= 1'b0;
    else        dev_strobe <= beat_good;
  end

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = csr_rd;
      4'h4:    reg_rdata = act_addr;
      4'h8:    reg_rdata = 32'(act_cnt);
      default: reg_rdata = '0;
    endcase
  end

  // R4: a stalled request keeps its address
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("address changed while stalled");

  // R12: draining always shows a pending bus cycle
  p_drain_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> (hold && mem_req_valid))
    else $error("drain without pending cycle");
endmodule

// File: tb/dbd_dma_chan_test.sv
module dbd_dma_chan_test;
  localparam logic [31:0] EN_DMA  = 32'h1 << 9;
  localparam logic [31:0] EN_CNT  = 32'h1 << 13;
  localparam logic [31:0] EN_NEXT = 32'h1 << 24;
  localparam logic [31:0] INT_EN  = 32'h1 << 4;
  localparam logic [31:0] TCI_DIS = 32'h1 << 23;
  localparam logic [31:0] WR_DIR  = 32'h1 << 8;
  localparam logic [31:0] BST4    = 32'h0 << 18;
  localparam logic [31:0] BST8    = 32'h1 << 18;
  localparam logic [31:0] BST1    = 32'h2 << 18;
  localparam logic [31:0] BST16   = 32'h3 << 18;
  localparam logic [31:0] IDW     = 32'h5000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write, mem_req_last;
  logic [31:0] mem_req_addr;
  logic mem_err = 1'b0, dev_irq = 1'b0, dev_strobe, irq;

  int checks = 0, failures = 0, nb = 0, cyc = 0, strobes = 0;
  logic [31:0] b_addr [0:63];
  int          b_cyc  [0:63];
  logic        b_last [0:63];
  bit done = 0;

  dbd_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_write(mem_req_write), .mem_req_last(mem_req_last),
    .mem_err(mem_err), .dev_irq(dev_irq), .dev_strobe(dev_strobe), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (mem_req_valid && mem_req_ready && nb < 64) begin
      b_addr[nb] = mem_req_addr;
      b_cyc[nb]  = cyc;
      b_last[nb] = mem_req_last;
      nb++;
    end
    if (dev_strobe) strobes++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    mem_err = 1'b0;
    mem_req_ready = 1'b1;
    wr(4'h0, 32'h80);
    idle(3);
    nb = 0;
    strobes = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v);
    chk("R1 csr", v, IDW);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 valid", {31'b0, mem_req_valid}, 0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    clean();
    mem_req_ready = 1'b0;
    wr(4'h8, 5); wr(4'h4, 32'h40);
    rd(4'h0, v);
    chk("R2 ignored when disabled", {31'b0, v[26]}, 0);
    wr(4'h0, EN_DMA | EN_CNT);
    wr(4'h8, 32'h0100_0003); wr(4'h4, 32'h1000);
    rd(4'h0, v);
    chk("R2 active loaded", {31'b0, v[26]}, 1);
    rd(4'h4, v);
    chk("R2 addr readback", v, 32'h1000);
    rd(4'h8, v);
    chk("R2 count 24-bit", v, 32'h3);
    idle(2);
    chk("R4 stalled valid", {31'b0, mem_req_valid}, 1);
    chk("R4 stalled addr", mem_req_addr, 32'h1000);
  endtask

  task automatic t_beats();
    logic [31:0] v;
    clean();
    wr(4'h0, EN_DMA | EN_CNT | BST4 | WR_DIR);
    wr(4'h8, 6); wr(4'h4, 32'h100);
    idle(20);
    chk("R4 beat count", nb, 6);
    for (int i = 0; i < 6; i++) chk("R4 beat addr", b_addr[i], 32'h100 + i);
    chk("R4 write dir", {31'b0, mem_req_write}, 1);
    chk("R5 burst4 last@3", {31'b0, b_last[3]}, 1);
    chk("R5 burst4 no last@0", {31'b0, b_last[0]}, 0);
    chk("R5 transfer last@5", {31'b0, b_last[5]}, 1);
    chk("R5 back to back", b_cyc[1] - b_cyc[0], 1);
    chk("R5 idle after burst", b_cyc[4] - b_cyc[3], 2);
    chk("R14 strobes", strobes, 6);
    rd(4'h0, v);
    chk("R6 tc set", {31'b0, v[14]}, 1);
    chk("R6 int pend", {31'b0, v[0]}, 1);
    chk("R6 active cleared", {31'b0, v[26]}, 0);
    rd(4'h8, v);
    chk("R4 count zero", v, 0);
    rd(4'h4, v);
    chk("R4 final addr", v, 32'h106);
    rd(4'h0, v);
    wr(4'h0, v);
    rd(4'h0, v);
    chk("R8 write-back ack", v, IDW | EN_DMA | EN_CNT | WR_DIR);
    clean();
    wr(4'h0, EN_DMA | EN_CNT | BST8);
    wr(4'h8, 10); wr(4'h4, 32'h0);
    idle(25);
    chk("R5 burst8 count", nb, 10);
    chk("R5 burst8 last@7", {31'b0, b_last[7]}, 1);
    chk("R5 burst8 no last@6", {31'b0, b_last[6]}, 0);
    chk("R5 burst8 last@9", {31'b0, b_last[9]}, 1);
    chk("R5 burst8 gap", b_cyc[8] - b_cyc[7], 2);
    chk("R4 write dir low", {31'b0, mem_req_write}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    clean();
    mem_req_ready = 1'b0;
    wr(4'h0, EN_DMA | EN_CNT | BST16 | EN_NEXT);
    wr(4'h8, 3); wr(4'h4, 32'h200);
    wr(4'h8, 2); wr(4'h4, 32'h300);
    wr(4'h8, 9); wr(4'h4, 32'h400);
    rd(4'h0, v);
    chk("R3 both loaded", {30'b0, v[27:26]}, 3);
    rd(4'h4, v);
    chk("R3 active kept", v, 32'h200);
    chk("R4 hold addr", mem_req_addr, 32'h200);
    chk("R4 no beat while stalled", nb, 0);
    mem_req_ready = 1'b1;
    idle(15);
    chk("R7 chained beats", nb, 5);
    chk("R7 a0", b_addr[0], 32'h200);
    chk("R7 a2", b_addr[2], 32'h202);
    chk("R7 a3 from queue", b_addr[3], 32'h300);
    chk("R7 a4", b_addr[4], 32'h301);
    chk("R5 last at end of first", {31'b0, b_last[2]}, 1);
    chk("R5 last at end of second", {31'b0, b_last[4]}, 1);
    chk("R7 one idle between", b_cyc[3] - b_cyc[2], 2);
    rd(4'h0, v);
    chk("R7 loaded flags clear", {30'b0, v[27:26]}, 0);
    chk("R6 tc after chain", {31'b0, v[14]}, 1);
    rd(4'h4, v);
    chk("R7 final addr", v, 32'h302);
    clean();
    mem_req_ready = 1'b0;
    wr(4'h0, EN_DMA | EN_CNT);
    wr(4'h8, 1); wr(4'h4, 32'h10);
    wr(4'h8, 1); wr(4'h4, 32'h20);
    rd(4'h0, v);
    chk("R3 queue off drops", {31'b0, v[27]}, 0);
    mem_req_ready = 1'b1;
    idle(6);
    chk("R3 queue off one beat", nb, 1);
  endtask

  task automatic t_tci();
    logic [31:0] v;
    clean();
    wr(4'h0, EN_DMA | EN_CNT | INT_EN | TCI_DIS | BST1);
    wr(4'h8, 1); wr(4'h4, 32'h50);
    idle(5);
    rd(4'h0, v);
    chk("R6 tc with tci off", {31'b0, v[14]}, 1);
    chk("R6 no int pend", {31'b0, v[0]}, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    clean();
    mem_err = 1'b1;
    wr(4'h0, EN_DMA | EN_CNT | INT_EN);
    wr(4'h8, 4); wr(4'h4, 32'h80);
    idle(6);
    chk("R10 one beat then stop", nb, 1);
    chk("R10 no request", {31'b0, mem_req_valid}, 0);
    rd(4'h0, v);
    chk("R10 err pend", {31'b0, v[1]}, 1);
    chk("R9 irq on error", {31'b0, irq}, 1);
    rd(4'h8, v);
    chk("R10 count kept", v, 4);
    rd(4'h4, v);
    chk("R10 addr kept", v, 32'h80);
    chk("R14 no strobe on error", strobes, 0);
    mem_err = 1'b0;
    rd(4'h0, v);
    wr(4'h0, v);
    chk("R8 err acked irq low", {31'b0, irq}, 0);
    rd(4'h0, v);
    chk("R8 err cleared", {31'b0, v[1]}, 0);
  endtask

  task automatic t_devirq();
    logic [31:0] v;
    clean();
    wr(4'h0, INT_EN);
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    rd(4'h0, v);
    chk("R11 int pend", {31'b0, v[0]}, 1);
    chk("R11 no tc", {31'b0, v[14]}, 0);
    chk("R9 irq device", {31'b0, irq}, 1);
    wr(4'h0, 32'h0);
    rd(4'h0, v);
    chk("R9 irq masked", {31'b0, irq}, 0);
    chk("R8 zero write keeps flag", {31'b0, v[0]}, 1);
    wr(4'h0, 32'h1);
    rd(4'h0, v);
    chk("R8 w1c int pend", {31'b0, v[0]}, 0);
  endtask

  task automatic t_drain();
    logic [31:0] v;
    clean();
    mem_req_ready = 1'b0;
    wr(4'h0, EN_DMA | EN_CNT | INT_EN);
    wr(4'h8, 4); wr(4'h4, 32'h900);
    wr(4'h0, 32'h80 | EN_DMA);
    rd(4'h0, v);
    chk("R12 draining state", v, IDW | (32'h1 << 2) | (32'h1 << 10));
    idle(3);
    chk("R12 request held", {31'b0, mem_req_valid}, 1);
    chk("R12 held addr", mem_req_addr, 32'h900);
    mem_req_ready = 1'b1;
    idle(1);
    rd(4'h0, v);
    chk("R12 drain done", v, IDW);
    chk("R12 valid low", {31'b0, mem_req_valid}, 0);
    chk("R14 no strobe in drain", strobes, 0);
  endtask

  task automatic t_nocount();
    logic [31:0] v;
    clean();
    wr(4'h0, EN_DMA | BST1);
    wr(4'h8, 2); wr(4'h4, 32'h500);
    idle(10);
    wr(4'h0, 32'h0);
    idle(3);
    chk("R13 runs past count", {31'b0, nb > 2}, 1);
    chk("R13 burst1 gap", b_cyc[1] - b_cyc[0], 2);
    rd(4'h8, v);
    chk("R13 count frozen", v, 2);
    rd(4'h4, v);
    chk("R13 addr advanced", v, 32'h500 + nb);
    rd(4'h0, v);
    chk("R13 no tc", {31'b0, v[14]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_beats();
    t_chain();
    t_tci();
    t_error();
    t_devirq();
    t_drain();
    t_nocount();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule